// File: doc/BRIEF.md
# Interrupt Raw/Masked Status Controller

This block gathers three interrupt conditions of an external memory controller and raises one combined interrupt line. The first condition is the release of an active-low wait input, seen as a rising edge on it. The second is a one-cycle pulse reporting that an asynchronous access timed out. The third is a one-cycle pulse reporting an unsupported addressing mode, called here a line trap. Each condition has a raw status bit, which records every event. Each also has a masked status bit, which records only the events that occur while that source is enabled.

Software sets enables through a write-1-to-set register and removes them through a write-1-to-clear register. It acknowledges an event by writing 1 to the raw status bit, which also clears the masked copy. All four registers use the same bit for a given source. The wait input comes from outside the clock domain, so it passes through a synchronizer before edge detection.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, every raw bit, masked bit and enable reads 0 and `irq_o` is low.
- R2: A high cycle on `timeout_evt_i` sets raw bit 0, which is visible on a read in the next cycle.
- R3: A high cycle on `trap_evt_i` sets raw bit 1, which is visible on a read in the next cycle.
- R4: A 0-to-1 transition of `wait_ni` sets raw bit 2. The input is held high during reset, it passes two synchronizer flops, and the bit is readable once the third clock edge after the transition has passed. A 1-to-0 transition sets nothing.
- R5: Writing to address 0 clears every raw bit whose data bit is 1, and also the masked bit of the same index. Data bits that are 0 leave both bits unchanged.
- R6: A masked bit sets only when its event occurs while its enable is already 1. Enabling a source after its event does not set its masked bit. A masked bit is never 1 while its raw bit is 0.
- R7: Writing to address 2 sets every enable whose data bit is 1. Data bits that are 0, and writes to other addresses, leave the enables unchanged.
- R8: Writing to address 3 clears every enable whose data bit is 1, and data bits that are 0 have no effect. Clearing an enable does not clear a masked bit that is already set.
- R9: When an event and a write-1-to-clear of the same raw bit fall in the same cycle, the bit is set afterwards. Its masked bit is also set if the source was enabled.
- R10: `irq_o` is high exactly when at least one masked bit is 1.
- R11: While `req_i` is high and `we_i` is low, `rdata_o` returns the raw bits for address 0, the masked bits for address 1, and the enables for address 2 or 3. The bits are timeout at bit 0, line trap at bit 1 and wait at bit 2. All upper bits read 0, and `rdata_o` is 0 when no read is requested. Writes to address 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_ni | input | 1 | Active-low wait pin, asynchronous to clk_i |
| timeout_evt_i | input | 1 | One-cycle asynchronous-timeout event |
| trap_evt_i | input | 1 | One-cycle unsupported-addressing event |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select: 0 raw, 1 masked, 2 enable set, 3 enable clear |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
Directed patterns come first. An event with the source disabled must set the raw bit but not the masked bit. Enabling the source after that event must leave the masked bit clear, which tells apart a masked bit that latches with a gated copy of raw. Further directed cases cover a clear that coincides with an event, writes of 0 data, writes to the read-only masked register, and both directions of the wait pin. Random traffic then mixes event pulses, wait toggles, reads and writes at all four addresses. Every read and every cycle of `irq_o` is compared with a bench model of the registers.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_SRC = 3;
  localparam int ADDR_W  = 2;

  localparam int SRC_TIMEOUT = 0;
  localparam int SRC_TRAP    = 1;
  localparam int SRC_WAIT    = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_RAW    = 2'd0,
    REG_MASKED = 2'd1,
    REG_EN_SET = 2'd2,
    REG_EN_CLR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wait_rise_det.sv
module wait_rise_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_ni,
  output logic rise_o
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  // Reset to the released level so leaving reset gives no edge.
  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[CHAIN_W-2:0], wait_ni};
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/status_bit_bank.sv
module status_bit_bank #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] masked_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic raw_q, masked_q;

    // Set dominates a coincident clear.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        raw_q    <= 1'b0;
        masked_q <= 1'b0;
      end else begin
        raw_q    <= (raw_q & ~clr_i[i]) | evt_i[i];
        masked_q <= (masked_q & ~clr_i[i]) | (evt_i[i] & en_i[i]);
      end
    end

    assign raw_o[i]    = raw_q;
    assign masked_o[i] = masked_q;
  end
endmodule

// File: rtl/enable_bank.sv
module enable_bank #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_i) & ~clr_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/reg_port.sv
module reg_port
  import irq_status_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 32
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      raw_i,
  input  logic [N-1:0]      masked_i,
  input  logic [N-1:0]      en_i,
  output logic [N-1:0]      raw_clr_o,
  output logic [N-1:0]      en_set_o,
  output logic [N-1:0]      en_clr_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int PAD_W = DW - N;

  reg_sel_e     sel;
  logic         wr, rd;
  logic [N-1:0] rd_val;

  assign sel = reg_sel_e'(addr_i);
  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;

  assign raw_clr_o = (wr && sel == REG_RAW)    ? wdata_i : '0;
  assign en_set_o  = (wr && sel == REG_EN_SET) ? wdata_i : '0;
  assign en_clr_o  = (wr && sel == REG_EN_CLR) ? wdata_i : '0;

  always_comb begin
    unique case (sel)
      REG_RAW:    rd_val = raw_i;
      REG_MASKED: rd_val = masked_i;
      REG_EN_SET,
      REG_EN_CLR: rd_val = en_i;
      default:    rd_val = '0;
    endcase
  end

  assign rdata_o = rd ? {{PAD_W{1'b0}}, rd_val} : '0;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wait_ni,
  input  logic              timeout_evt_i,
  input  logic              trap_evt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] evt, raw_q, masked_q, en_q;
  logic [NUM_SRC-1:0] raw_clr, en_set, en_clr;
  logic               wait_rise;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];

  wait_rise_det #(.SYNC_STAGES(SYNC_STAGES)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wait_ni(wait_ni),
    .rise_o (wait_rise)
  );

  always_comb begin
    evt              = '0;
    evt[SRC_TIMEOUT] = timeout_evt_i;
    evt[SRC_TRAP]    = trap_evt_i;
    evt[SRC_WAIT]    = wait_rise;
  end

  reg_port #(.N(NUM_SRC), .DW(DATA_W)) u_regs (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i[NUM_SRC-1:0]),
    .raw_i    (raw_q),
    .masked_i (masked_q),
    .en_i     (en_q),
    .raw_clr_o(raw_clr),
    .en_set_o (en_set),
    .en_clr_o (en_clr),
    .rdata_o  (rdata_o)
  );

  enable_bank #(.N(NUM_SRC)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (en_set),
    .clr_i (en_clr),
    .en_o  (en_q)
  );

  status_bit_bank #(.N(NUM_SRC)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .en_i    (en_q),
    .clr_i   (raw_clr),
    .raw_o   (raw_q),
    .masked_o(masked_q)
  );

  assign irq_o = |masked_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int N = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_i,
  input logic         we_i,
  input logic [1:0]   addr_i,
  input logic [N-1:0] wdata_i,
  input logic [N-1:0] evt,
  input logic [N-1:0] raw_q,
  input logic [N-1:0] masked_q,
  input logic [N-1:0] en_q,
  input logic         irq_o
);
  logic wr_raw, wr_set, wr_clr;
  assign wr_raw = req_i && we_i && addr_i == 2'd0;
  assign wr_set = req_i && we_i && addr_i == 2'd2;
  assign wr_clr = req_i && we_i && addr_i == 2'd3;

  AST_EVT_SETS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(evt)) == $past(evt)));  // R9
  AST_RAW_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_raw |=> ((raw_q & $past(wdata_i & ~evt)) == '0));  // R5
  AST_MASKED_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_raw |=> ((masked_q & $past(wdata_i & ~evt)) == '0));  // R5
  AST_MASKED_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((masked_q & ~$past(masked_q) & ~$past(en_q)) == '0));  // R6
  AST_MASKED_IN_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((masked_q & ~raw_q) == '0));  // R6
  AST_IRQ_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (masked_q != '0));  // R10
  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));  // R7
  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((en_q & $past(wdata_i)) == '0));  // R8
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(en_q));  // R7
endmodule

bind irq_status_ctrl irq_status_chk #(.N(irq_status_pkg::NUM_SRC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i[irq_status_pkg::NUM_SRC-1:0]),
  .evt     (evt),
  .raw_q   (raw_q),
  .masked_q(masked_q),
  .en_q    (en_q),
  .irq_o   (irq_o)
);

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wait_ni = 1'b1;
  logic          timeout_evt_i = 1'b0, trap_evt_i = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [1:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [2:0] m_raw = '0, m_msk = '0, m_en = '0;
  logic       m_q1 = 1'b1, m_q2 = 1'b1, m_q3 = 1'b1;
  logic       wait_lvl = 1'b1;

  always #2.5 clk = ~clk;

  irq_status_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .wait_ni(wait_ni),
    .timeout_evt_i(timeout_evt_i), .trap_evt_i(trap_evt_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {29'b0, m_raw};
      2'd1:    return {29'b0, m_msk};
      default: return {29'b0, m_en};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic rq, input logic w, input logic [1:0] a,
                     input logic [DW-1:0] d, input logic to, input logic tr, input string tag);
    logic       rise;
    logic [2:0] ev, clr;
    @(negedge clk);
    req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    timeout_evt_i = to; trap_evt_i = tr; wait_ni = wait_lvl;
    #1;
    if (rq && !w) chk(tag, rdata_o, exp_read(a));
    else          chk("R11 idle", rdata_o, '0);
    chk("R10", {31'b0, irq_o}, {31'b0, |m_msk});
    @(posedge clk);
    rise = m_q2 & ~m_q3;
    m_q3 = m_q2; m_q2 = m_q1; m_q1 = wait_lvl;
    ev  = {rise, tr, to};
    clr = (rq && w && a == 2'd0) ? d[2:0] : 3'b0;
    m_raw = (m_raw & ~clr) | ev;
    m_msk = (m_msk & ~clr) | (ev & m_en);
    if (rq && w && a == 2'd2) m_en = m_en | d[2:0];
    if (rq && w && a == 2'd3) m_en = m_en & ~d[2:0];
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, ""); endtask
  task automatic rd(input logic [1:0] a, input string tag); cyc(1, 0, a, 0, 0, 0, tag); endtask
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d); cyc(1, 1, a, d, 0, 0, ""); endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(0, "R1"); rd(1, "R1"); rd(2, "R1"); rd(3, "R1");
    chk("R1 raw", rdata_o, '0);

    // R2 timeout with source disabled
    cyc(0, 0, 0, 0, 1, 0, "");
    rd(0, "R2"); chk("R2 direct", rdata_o, 32'h1);
    rd(1, "R6");
    // late enable must not flag the earlier event
    wr(2, 32'h1);
    rd(1, "R6"); chk("R6 retro", rdata_o, 32'h0);
    rd(2, "R7"); rd(3, "R11");
    wr(0, 32'h1);
    rd(0, "R5");
    cyc(0, 0, 0, 0, 1, 0, "");
    rd(1, "R6"); chk("R6 enabled", rdata_o, 32'h1);
    wr(0, 32'h0); rd(0, "R5"); rd(1, "R5");
    wr(1, 32'h7); rd(1, "R11"); rd(0, "R11");
    wr(2, 32'h0); rd(2, "R7");
    wr(3, 32'h1); rd(3, "R8"); rd(1, "R8");
    wr(3, 32'h0); rd(2, "R8");
    wr(0, 32'h1); rd(0, "R5"); rd(1, "R5");

    // R3 trap with coincident clear (R9)
    wr(2, 32'h2);
    cyc(1, 1, 0, 32'h2, 0, 1, "");
    rd(0, "R9"); chk("R3 direct", rdata_o, 32'h2);
    rd(1, "R9");
    wr(0, 32'h7);

    // R4 wait falling edge sets nothing, rising edge sets bit 2
    wr(2, 32'h4);
    wait_lvl = 1'b0;
    repeat (5) idle();
    rd(0, "R4"); chk("R4 fall", rdata_o, 32'h0);
    wait_lvl = 1'b1;
    idle(); idle(); idle();
    rd(0, "R4"); chk("R4 rise", rdata_o, 32'h4);
    rd(1, "R4");
    wr(0, 32'h4); wr(3, 32'h7);

    // random traffic
    for (int i = 0; i < 5000; i++) begin
      logic [1:0]    a;
      logic [DW-1:0] d;
      int            op;
      op = $urandom % 4;
      a  = 2'($urandom % 4);
      d  = $urandom;
      if ($urandom % 50 == 0) wait_lvl = ~wait_lvl;
      cyc(op != 0, op == 2, a, d, ($urandom % 7) == 0, ($urandom % 9) == 0,
          a == 2'd0 ? "R5 rand" : a == 2'd1 ? "R6 rand" : "R11 rand");
    end
    wait_lvl = 1'b1;
    repeat (4) idle();
    rd(0, "R11"); rd(1, "R11"); rd(2, "R11");

    done = 1;
    finish_run();
  end
endmodule